// File: doc/BRIEF.md
# Block-Based Memory CRC-16 Engine

This engine computes a 16-bit cyclic redundancy check over a contiguous region of a byte-wide memory. A request gives a starting block number and a number of blocks, and every block is 4096 bytes. The engine walks the region through a synchronous read port that returns data one cycle after the read strobe. It folds each byte into a CCITT-polynomial register and then presents the finished checksum with a one-cycle completion pulse.

The register is preset to all ones, and each byte enters least-significant bit first. The reported value is the bit-reversed, complemented register. A host can therefore append the reported value to the data, low byte first, and obtain a fixed residue on a later check. While memory read protection is asserted, a request performs no reads and returns an error pulse. A request for more blocks than the block index space holds is refused in the same way. Requests that arrive during a scan are dropped.

Top module: `mem_crc_engine`

## Requirements
- R1: After reset, busy, done, err and mem_rd are low and crc_out reads 0000h.
- R2: An accepted request of C blocks starting at block B issues exactly C*4096 reads on consecutive cycles. The first address is B*4096 and each later address is one higher. Addresses wrap modulo 2^24.
- R3: crc_out equals the bit-reversed complement of a register preset to FFFFh. Each data byte is shifted into that register LSB first, using the polynomial x^16+x^12+x^5+1. The byte string "123456789" therefore yields 906Eh.
- R4: Suppose a block holds data whose final two bytes are that data's reported CRC, low byte first. Scanning that block leaves the reflected register at F0B8h, so crc_out reads 0F47h.
- R5: The request is sampled on the clock edge where start is high. For a nonzero block count, busy rises at that edge. busy falls, and done is high for exactly one cycle, at the edge N+1 cycles later, where N is the byte count.
- R6: crc_out holds its value from the done pulse until the next accepted request.
- R7: A start pulse while busy is high is ignored. The running scan keeps its addresses, length and result, and err stays low.
- R8: A start with rd_protect high, or with a block count above 4096, produces no reads. It leaves busy low and done low, pulses err for one cycle, and leaves crc_out unchanged.
- R9: A start with a block count of zero performs no reads. It pulses done at the edge that samples start, and crc_out reads 0000h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled on the rising edge |
| blk_index | input | 12 | First 4096-byte block of the region |
| blk_count | input | 13 | Number of blocks, 0 to 4096 |
| rd_protect | input | 1 | Memory read protection; refuses requests |
| mem_addr | output | 24 | Byte read address |
| mem_rd | output | 1 | Read strobe |
| mem_data | input | 8 | Read data, valid the cycle after mem_rd |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal pulse |
| crc_out | output | 16 | Finished checksum |

## Verification
Each scan is compared against an independent right-shifting reflected model, which is itself checked against the "123456789" value. That comparison catches a wrong bit order, a wrong preset or a missing reversal. The bench runs a scan that starts in the top block and wraps to address zero; a design that carried into a 25th bit, or stopped at the top, would give wrong addresses or a short count. A block that ends in its own checksum must give the fixed residue, which fails on any byte lost at the read latency boundary. A start injected mid-scan, a protected request, an oversized count and a zero count each check a separate control corner. A design that got one of these wrong would restart, read memory, or leave the result changed.

// File: rtl/mcrc_pkg.sv
package mcrc_pkg;

    localparam logic [15:0] CRC_POLY   = 16'h1021;
    localparam logic [15:0] CRC_PRESET = 16'hFFFF;

    // Fold one byte into a left-shifting register, data bit 0 entering first.
    function automatic logic [15:0] crc_fold_byte(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[15] ^ b[i];
            r  = {r[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
        end
        return r;
    endfunction

    function automatic logic [15:0] bit_rev16(input logic [15:0] v);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = v[15-i];
        return r;
    endfunction

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

endpackage

// File: rtl/mcrc_addr_gen.sv
module mcrc_addr_gen #(
    parameter int BLK_LOG2 = 12,
    parameter int IDX_W    = 12,
    localparam int ADDR_W  = IDX_W + BLK_LOG2,
    localparam int CNT_W   = IDX_W + 1,
    localparam int LEN_W   = CNT_W + BLK_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [IDX_W-1:0]  idx,
    input  logic [CNT_W-1:0]  count,
    output logic              rd_en,
    output logic              rd_last,
    output logic [ADDR_W-1:0] rd_addr
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  left;
    } agen_t;

    agen_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.addr = {idx, {BLK_LOG2{1'b0}}};
            st_d.left = {count, {BLK_LOG2{1'b0}}};
        end else if (st_q.left != '0) begin
            st_d.addr = st_q.addr + ADDR_W'(1);
            st_d.left = st_q.left - LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_en   = (st_q.left != '0);
    assign rd_last = (st_q.left == LEN_W'(1));
    assign rd_addr = st_q.addr;

    // R2: back-to-back reads step the address by exactly one byte
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + ADDR_W'(1)));

    // R2: the final read of a scan is followed by silence
    a_r2_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_last && !load) |=> !rd_en);

endmodule

// File: rtl/mcrc_fold.sv
module mcrc_fold
    import mcrc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        req_vld,
    input  logic        req_last,
    input  logic [7:0]  data,
    output logic        fold_last,
    output logic [15:0] crc_reg
);

    typedef struct packed {
        logic [15:0] crc;
        logic        vld;
        logic        last;
    } fold_t;

    fold_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = req_vld;
        st_d.last = req_vld & req_last;
        if (init) begin
            st_d.crc = CRC_PRESET;
        end else if (st_q.vld) begin
            st_d.crc = crc_fold_byte(st_q.crc, data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.crc  <= CRC_PRESET;
            st_q.vld  <= 1'b0;
            st_q.last <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fold_last = st_q.vld & st_q.last;
    assign crc_reg   = st_q.crc;

    // R5: no data byte arrives after the last one of a scan
    a_r5_last_is_final: assert property (@(posedge clk) disable iff (!rst_n)
        fold_last |=> !st_q.vld);

    // R6: register changes only on a fold or a fresh preset
    a_r6_crc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.vld && !init) |=> $stable(st_q.crc));

endmodule

// File: rtl/mem_crc_engine.sv
module mem_crc_engine
    import mcrc_pkg::*;
#(
    parameter int BLK_LOG2 = 12,
    parameter int IDX_W    = 12,
    localparam int ADDR_W  = IDX_W + BLK_LOG2,
    localparam int CNT_W   = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  blk_index,
    input  logic [CNT_W-1:0]  blk_count,
    input  logic              rd_protect,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [7:0]        mem_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [15:0]       crc_out
);

    localparam logic [CNT_W-1:0] MAX_BLOCKS = CNT_W'(1) << IDX_W;

    typedef struct packed {
        scan_state_e state;
        logic        done;
        logic        err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic        req_seen;
    logic        req_refused;
    logic        req_ok;
    logic        req_empty;
    logic        ag_last;
    logic        fold_last;
    logic [15:0] crc_reg;

    assign req_seen    = start && (ctl_q.state == ST_IDLE);
    assign req_refused = req_seen && (rd_protect || (blk_count > MAX_BLOCKS));
    assign req_ok      = req_seen && !req_refused;
    assign req_empty   = (blk_count == '0);

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.err  = req_refused;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_ok) begin
                    if (req_empty) ctl_d.done  = 1'b1;
                    else           ctl_d.state = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (fold_last) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.done  = 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.done  <= 1'b0;
            ctl_q.err   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    mcrc_addr_gen #(
        .BLK_LOG2 (BLK_LOG2),
        .IDX_W    (IDX_W)
    ) u_agen (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (req_ok),
        .idx     (blk_index),
        .count   (blk_count),
        .rd_en   (mem_rd),
        .rd_last (ag_last),
        .rd_addr (mem_addr)
    );

    mcrc_fold u_fold (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (req_ok),
        .req_vld   (mem_rd),
        .req_last  (ag_last),
        .data      (mem_data),
        .fold_last (fold_last),
        .crc_reg   (crc_reg)
    );

    assign busy    = (ctl_q.state == ST_SCAN);
    assign done    = ctl_q.done;
    assign err     = ctl_q.err;
    assign crc_out = ~bit_rev16(crc_reg);

    // R5: completion is a single-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: done and busy are never high together
    a_r5_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    // R2: reads occur only during a scan
    a_r2_rd_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> busy);

    // R8: a protected request is refused with an error pulse
    a_r8_protect_err: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && rd_protect) |=> (err && !busy && !done && !mem_rd));

    // R7: a start during a scan raises no error and keeps the scan running
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> !err);

    // R6: result is frozen while idle and no start arrives
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(crc_out));

endmodule

// File: tb/tb_mem_crc_engine.sv
module tb_mem_crc_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] blk_index = '0;
    logic [12:0] blk_count = '0;
    logic        rd_protect = 1'b0;
    logic [23:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_data = '0;
    logic        busy, done, err;
    logic [15:0] crc_out;

    always #4 clk = ~clk;  // 125 MHz

    mem_crc_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_index(blk_index),
        .blk_count(blk_count), .rd_protect(rd_protect), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_data(mem_data), .busy(busy), .done(done),
        .err(err), .crc_out(crc_out)
    );

    int tests = 0;
    int fails = 0;

    // Overrides let one test plant a checksum at the end of a block.
    logic        ovr_en = 1'b0;
    logic [23:0] ovr_a  = '0;
    logic [7:0]  ovr_b0 = '0;
    logic [7:0]  ovr_b1 = '0;

    function automatic logic [7:0] pattern(input logic [23:0] a);
        return 8'(a * 24'd37) ^ a[15:8] ^ 8'(a[23:16] * 8'd13);
    endfunction

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        if (ovr_en && a == ovr_a)          return ovr_b0;
        if (ovr_en && a == ovr_a + 24'd1)  return ovr_b1;
        return pattern(a);
    endfunction

    // Reflected, right-shifting reference step.
    function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        return r;
    endfunction

    // Monitor and behavioural memory.
    logic        mon_clr = 1'b0;
    logic [23:0] mon_base = '0;
    logic [23:0] exp_addr = '0;
    logic [15:0] model_c = 16'hFFFF;
    int          rd_cnt = 0;
    int          addr_bad = 0;
    int          rd_total = 0;

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_data <= mem_byte(mem_addr);
            rd_total <= rd_total + 1;
        end
        if (mon_clr) begin
            exp_addr <= mon_base;
            model_c  <= 16'hFFFF;
            rd_cnt   <= 0;
            addr_bad <= 0;
        end else if (mem_rd) begin
            if (mem_addr != exp_addr) addr_bad <= addr_bad + 1;
            exp_addr <= exp_addr + 24'd1;
            model_c  <= ref_step(model_c, mem_byte(mem_addr));
            rd_cnt   <= rd_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [11:0] idx;
        logic [12:0] cnt;
        logic        prot;
        logic        exp_err;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{12'd0,    13'd1,    1'b0, 1'b0},
        '{12'd5,    13'd2,    1'b0, 1'b0},
        '{12'd4095, 13'd2,    1'b0, 1'b0},   // wraps to address 0
        '{12'd7,    13'd0,    1'b0, 1'b0},   // empty request
        '{12'd3,    13'd1,    1'b1, 1'b1},   // protected
        '{12'd0,    13'd4097, 1'b0, 1'b1},   // too many blocks
        '{12'd100,  13'd1,    1'b0, 1'b0}
    };

    // Drives one request; optionally injects a start mid-scan at cycle inj_k.
    task automatic run_req(input logic [11:0] idx, input logic [12:0] cnt,
                           input logic prot, input logic exp_err, input int inj_k);
        int          n;
        int          k;
        int          tot0;
        logic [15:0] prev;
        n    = int'(cnt) * 4096;
        prev = crc_out;
        @(negedge clk);
        blk_index  = idx;
        blk_count  = cnt;
        rd_protect = prot;
        mon_base   = {idx, 12'h000};
        mon_clr    = 1'b1;
        start      = 1'b1;
        tot0       = rd_total;
        @(negedge clk);
        start   = 1'b0;
        mon_clr = 1'b0;
        rd_protect = 1'b0;
        if (exp_err) begin
            check("R8 err pulse", {31'b0, err}, 32'd1);
            check("R8 busy low", {31'b0, busy}, 32'd0);
            @(negedge clk);
            check("R8 err one cycle", {31'b0, err}, 32'd0);
            repeat (4) @(negedge clk);
            check("R8 no reads", rd_total - tot0, 32'd0);
            check("R8 crc unchanged", {16'b0, crc_out}, {16'b0, prev});
            check("R8 no done", {31'b0, done | busy}, 32'd0);
            return;
        end
        k = 0;
        while (!done && k < n + 20) begin
            @(negedge clk);
            k++;
            if (k == 1 && n > 0) check("R5 busy after start", {31'b0, busy}, 32'd1);
            if (k == inj_k) begin
                blk_index = idx + 12'd9;
                blk_count = 13'd3;
                start     = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        check("R5 done latency", k, (n == 0) ? 32'd0 : 32'(n + 1));
        check("R2 read count", rd_cnt, n);
        check("R2 address sequence", addr_bad, 32'd0);
        check(n == 0 ? "R9 empty crc" : "R3 crc value", {16'b0, crc_out}, {16'b0, ~model_c});
        if (inj_k > 0) check("R7 no err on busy start", {31'b0, err}, 32'd0);
        prev = crc_out;
        @(negedge clk);
        check("R5 done one cycle", {31'b0, done | busy}, 32'd0);
        repeat (3) @(negedge clk);
        check("R6 result held", {16'b0, crc_out}, {16'b0, prev});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] c;
        logic [15:0] r;
        string       s;
        repeat (3) @(negedge clk);
        check("R1 busy", {31'b0, busy}, 32'd0);
        check("R1 done/err", {30'b0, done, err}, 32'd0);
        check("R1 mem_rd", {31'b0, mem_rd}, 32'd0);
        check("R1 crc_out", {16'b0, crc_out}, 32'h0000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3: reference model against the standard check string
        s = "123456789";
        c = 16'hFFFF;
        foreach (s[i]) c = ref_step(c, s[i]);
        check("R3 model check value", {16'b0, ~c}, 32'h906E);

        for (int v = 0; v < NVEC; v++)
            run_req(VECS[v].idx, VECS[v].cnt, VECS[v].prot, VECS[v].exp_err, 0);

        // R7: start mid-scan is dropped
        run_req(12'd2, 13'd1, 1'b0, 1'b0, 50);

        // R4: block ending in its own checksum
        c = 16'hFFFF;
        for (int a = 0; a < 4094; a++) c = ref_step(c, pattern(24'h00A000 + 24'(a)));
        r = ~c;
        ovr_a  = 24'h00AFFE;
        ovr_b0 = r[7:0];
        ovr_b1 = r[15:8];
        ovr_en = 1'b1;
        run_req(12'h00A, 13'd1, 1'b0, 1'b0, 0);
        check("R4 residue", {16'b0, crc_out}, 32'h0F47);
        ovr_en = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule